// File: doc/BRIEF.md
# DMA Channel Trigger and Completion Controller

This block sits next to the transfer engine of a single DMA channel. It takes an asynchronous trigger line, brings it into the channel clock domain and turns a chosen edge into a trigger hit. It holds at most one hit until a unit of work that needs one is requested. The engine states which boundaries the burst it wants to issue begins: a block, a repeated (2D) block or a linked-list item. The block answers in the same cycle with a grant that says whether that burst may start.

The same block also watches the end-of-unit strobes from the engine. It raises a one-cycle completion event at the granularity chosen by configuration: each block, each repeated block, each linked-list item, or only the final linked-list item of the channel. A parameter says whether the channel supports repeated blocks. Without that support, the repeated-block settings fall back to block boundaries.

Top module: `dma_trig_ctrl`

## Requirements
- R1: While and right after synchronous reset (`rst` high), no trigger hit is pending and `cmpl_evt` is 0, so a gated request is not granted.
- R2: `cfg_pol` selects the hit edge: 2'b01 rising, 2'b10 falling. 2'b00 and 2'b11 mask the trigger: no hit is produced and no request is gated (`unit_go` equals `unit_req`).
- R3: A change on `trig_in` that is present before clock edge k makes a gated request grantable in the cycle after edge k+2, and not before.
- R4: With `cfg_tmode` 2'b00 and an active polarity, a request with `unit_blk_first` high needs a pending hit.
- R5: With `cfg_tmode` 2'b01, a request needs a hit when `unit_rblk_first` is high if HAS_2D is 1. If HAS_2D is 0, it needs one when `unit_blk_first` is high.
- R6: With `cfg_tmode` 2'b10, a request with `unit_link_first` high needs a pending hit.
- R7: With `cfg_tmode` 2'b11, every request needs a hit when `cfg_swreq` is 1. No request is gated when `cfg_swreq` is 0.
- R8: Only one hit is held at a time. Further hits while one is pending are dropped. A granted gated request consumes the pending hit.
- R9: `unit_go` is combinational. It is high exactly when `unit_req` is high and the request is either not gated or a hit is pending.
- R10: With `cfg_cmode` 2'b00, `cmpl_evt` is high for one cycle in the cycle after each cycle with `blk_end` high.
- R11: With `cfg_cmode` 2'b01, `cmpl_evt` follows `rblk_end` if HAS_2D is 1 and `blk_end` if HAS_2D is 0, one cycle later.
- R12: With `cfg_cmode` 2'b10, `cmpl_evt` follows `link_end` one cycle later.
- R13: With `cfg_cmode` 2'b11, `cmpl_evt` follows `link_end` only in cycles where `last_link` is also high, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Asynchronous trigger line |
| cfg_pol | input | 2 | Trigger edge select (01 rise, 10 fall, 00/11 masked) |
| cfg_tmode | input | 2 | Trigger gating granularity |
| cfg_cmode | input | 2 | Completion event granularity |
| cfg_swreq | input | 1 | Memory-to-memory (software-started) channel |
| unit_req | input | 1 | Engine wants to issue the next burst |
| unit_blk_first | input | 1 | Requested burst is the first of a block |
| unit_rblk_first | input | 1 | Requested burst is the first of a repeated block |
| unit_link_first | input | 1 | Requested burst is the first of a linked-list item |
| blk_end | input | 1 | Strobe: a block has finished |
| rblk_end | input | 1 | Strobe: a repeated block has finished |
| link_end | input | 1 | Strobe: a linked-list item, including its link update, has finished |
| last_link | input | 1 | The finishing item is the last of the channel |
| unit_go | output | 1 | Grant for the requested burst |
| cmpl_evt | output | 1 | One-cycle transfer-complete event |

## Verification
Two instances run side by side, one with and one without repeated-block support. The same stimulus therefore shows whether mode 01 follows its own boundary or the block boundary. Random runs change polarity, gating mode, completion mode and the software flag in epochs, while the trigger toggles at random. This separates rising from falling detection, masked from active polarity, and the gated from the ungated bursts of each mode. Directed sequences pin the exact three-edge latency of a trigger edge, show that two hits collapse into one grant, and show that the whole-channel completion mode ignores link ends that are not the last.

// File: rtl/dma_trig_pkg.sv
`timescale 1ns/1ps
package dma_trig_pkg;

   typedef enum logic [1:0] {
      POL_OFF_A = 2'b00,
      POL_RISE  = 2'b01,
      POL_FALL  = 2'b10,
      POL_OFF_B = 2'b11
   } trig_pol_e;

   typedef enum logic [1:0] {
      GATE_BLOCK = 2'b00,
      GATE_RBLK  = 2'b01,
      GATE_LINK  = 2'b10,
      GATE_BURST = 2'b11
   } gate_mode_e;

   typedef enum logic [1:0] {
      DONE_BLOCK = 2'b00,
      DONE_RBLK  = 2'b01,
      DONE_LINK  = 2'b10,
      DONE_CHAN  = 2'b11
   } done_mode_e;

   function automatic logic pol_active(trig_pol_e p);
      return (p == POL_RISE) || (p == POL_FALL);
   endfunction

endpackage

// File: rtl/dma_trig_sync.sv
`timescale 1ns/1ps
module dma_trig_sync
   import dma_trig_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      din,
   input  trig_pol_e pol,
   output logic      hit
);

   localparam int TOP = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dma_trig_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [TOP:0] chain_q;
   logic         prev_q;
   logic         level;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[TOP-1:0], din};
         prev_q  <= chain_q[TOP];
      end
   end

   assign level = chain_q[TOP];

   always_comb begin
      unique case (pol)
         POL_RISE: hit = level & ~prev_q;
         POL_FALL: hit = ~level & prev_q;
         default:  hit = 1'b0;
      endcase
   end

   AST_MASKED_NO_HIT: assert property (@(posedge clk) disable iff (rst)
      !pol_active(pol) |-> !hit); // R2

   AST_HIT_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
      hit |=> (prev_q != $past(prev_q))); // R3

endmodule

// File: rtl/dma_trig_gate.sv
`timescale 1ns/1ps
module dma_trig_gate
   import dma_trig_pkg::*;
#(
   parameter bit HAS_2D = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       hit,
   input  trig_pol_e  pol,
   input  gate_mode_e mode,
   input  logic       swreq,
   input  logic       req,
   input  logic       blk_first,
   input  logic       rblk_first,
   input  logic       link_first,
   output logic       go
);

   logic rblk_sel;
   logic need_raw;
   logic need;
   logic pend_q;
   logic consume;

   generate
      if (HAS_2D) begin : g_rblk_native
         assign rblk_sel = rblk_first;
      end else begin : g_rblk_fallback
         logic unused_rblk;
         assign unused_rblk = rblk_first;
         assign rblk_sel    = blk_first;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         GATE_BLOCK: need_raw = blk_first;
         GATE_RBLK:  need_raw = rblk_sel;
         GATE_LINK:  need_raw = link_first;
         default:    need_raw = swreq;
      endcase
   end

   assign need    = need_raw & pol_active(pol);
   assign go      = req & (~need | pend_q);
   assign consume = go & need;

   always_ff @(posedge clk) begin
      if (rst) pend_q <= 1'b0;
      else     pend_q <= hit | (pend_q & ~consume);
   end

   AST_HIT_CONSUMED: assert property (@(posedge clk) disable iff (rst)
      consume |=> (!pend_q || $past(hit))); // R8

   AST_HIT_KEPT: assert property (@(posedge clk) disable iff (rst)
      (pend_q && !consume) |=> pend_q); // R8

   AST_GATED_WAITS: assert property (@(posedge clk) disable iff (rst)
      (req && need && !pend_q) |-> !go); // R9

   AST_MASKED_PASS: assert property (@(posedge clk) disable iff (rst)
      (req && !pol_active(pol)) |-> go); // R2

endmodule

// File: rtl/dma_cmpl_sel.sv
`timescale 1ns/1ps
module dma_cmpl_sel
   import dma_trig_pkg::*;
#(
   parameter bit HAS_2D = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  done_mode_e mode,
   input  logic       blk_end,
   input  logic       rblk_end,
   input  logic       link_end,
   input  logic       last_link,
   output logic       evt
);

   logic rblk_src;
   logic fire;

   generate
      if (HAS_2D) begin : g_rend_native
         assign rblk_src = rblk_end;
      end else begin : g_rend_fallback
         logic unused_rend;
         assign unused_rend = rblk_end;
         assign rblk_src    = blk_end;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         DONE_BLOCK: fire = blk_end;
         DONE_RBLK:  fire = rblk_src;
         DONE_LINK:  fire = link_end;
         default:    fire = link_end & last_link;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) evt <= 1'b0;
      else     evt <= fire;
   end

   AST_EVT_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
      evt |-> $past(blk_end || rblk_end || link_end)); // R10

   AST_EVT_LAST_ONLY: assert property (@(posedge clk) disable iff (rst)
      (evt && $past(mode) == DONE_CHAN) |-> $past(last_link && link_end)); // R13

   AST_EVT_LINK_MODE: assert property (@(posedge clk) disable iff (rst)
      (evt && $past(mode) == DONE_LINK) |-> $past(link_end)); // R12

endmodule

// File: rtl/dma_trig_ctrl.sv
`timescale 1ns/1ps
module dma_trig_ctrl
   import dma_trig_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_2D      = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       trig_in,
   input  logic [1:0] cfg_pol,
   input  logic [1:0] cfg_tmode,
   input  logic [1:0] cfg_cmode,
   input  logic       cfg_swreq,
   input  logic       unit_req,
   input  logic       unit_blk_first,
   input  logic       unit_rblk_first,
   input  logic       unit_link_first,
   input  logic       blk_end,
   input  logic       rblk_end,
   input  logic       link_end,
   input  logic       last_link,
   output logic       unit_go,
   output logic       cmpl_evt
);

   trig_pol_e  pol;
   gate_mode_e tmode;
   done_mode_e cmode;
   logic       hit;

   assign pol   = trig_pol_e'(cfg_pol);
   assign tmode = gate_mode_e'(cfg_tmode);
   assign cmode = done_mode_e'(cfg_cmode);

   dma_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (trig_in),
      .pol (pol),
      .hit (hit)
   );

   dma_trig_gate #(.HAS_2D(HAS_2D)) u_gate (
      .clk        (clk),
      .rst        (rst),
      .hit        (hit),
      .pol        (pol),
      .mode       (tmode),
      .swreq      (cfg_swreq),
      .req        (unit_req),
      .blk_first  (unit_blk_first),
      .rblk_first (unit_rblk_first),
      .link_first (unit_link_first),
      .go         (unit_go)
   );

   dma_cmpl_sel #(.HAS_2D(HAS_2D)) u_cmpl (
      .clk       (clk),
      .rst       (rst),
      .mode      (cmode),
      .blk_end   (blk_end),
      .rblk_end  (rblk_end),
      .link_end  (link_end),
      .last_link (last_link),
      .evt       (cmpl_evt)
   );

   AST_GO_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      unit_go |-> unit_req); // R9

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> !cmpl_evt); // R1

endmodule

// File: tb/dma_trig_ctrl_tb.sv
`timescale 1ns/1ps
module dma_trig_ctrl_tb;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst, trig, sw, req, bf, rf, lf, be, re, le, ll;
   logic [1:0] pol, tm, cm;
   logic       go_2d, go_fl, ev_2d, ev_fl;

   dma_trig_ctrl #(.SYNC_STAGES(2), .HAS_2D(1'b1)) u_dut (
      .clk(clk), .rst(rst), .trig_in(trig), .cfg_pol(pol), .cfg_tmode(tm),
      .cfg_cmode(cm), .cfg_swreq(sw), .unit_req(req), .unit_blk_first(bf),
      .unit_rblk_first(rf), .unit_link_first(lf), .blk_end(be), .rblk_end(re),
      .link_end(le), .last_link(ll), .unit_go(go_2d), .cmpl_evt(ev_2d));

   dma_trig_ctrl #(.SYNC_STAGES(2), .HAS_2D(1'b0)) u_dut_flat (
      .clk(clk), .rst(rst), .trig_in(trig), .cfg_pol(pol), .cfg_tmode(tm),
      .cfg_cmode(cm), .cfg_swreq(sw), .unit_req(req), .unit_blk_first(bf),
      .unit_rblk_first(rf), .unit_link_first(lf), .blk_end(be), .rblk_end(re),
      .link_end(le), .last_link(ll), .unit_go(go_fl), .cmpl_evt(ev_fl));

   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;
   logic s1, s2, prv;
   logic pend_m [2];
   logic evt_m  [2];

   function automatic logic active_f();
      return (pol == 2'b01) || (pol == 2'b10);
   endfunction

   function automatic logic need_f(int i);
      if (!active_f()) return 1'b0;
      case (tm)
         2'b00:   return bf;
         2'b01:   return (i == 0) ? rf : bf;
         2'b10:   return lf;
         default: return sw;
      endcase
   endfunction

   function automatic logic fire_f(int i);
      case (cm)
         2'b00:   return be;
         2'b01:   return (i == 0) ? re : be;
         2'b10:   return le;
         default: return le & ll;
      endcase
   endfunction

   function automatic string go_tag();
      if (!active_f()) return "R2";
      if (!need_f(0) && !need_f(1)) return "R9";
      case (tm)
         2'b00:   return "R4";
         2'b01:   return "R5";
         2'b10:   return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic string ev_tag();
      case (cm)
         2'b00:   return "R10";
         2'b01:   return "R11";
         2'b10:   return "R12";
         default: return "R13";
      endcase
   endfunction

   task automatic chk(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // called just after a falling edge with inputs already driven
   task automatic step();
      logic hit_m;
      logic g;
      logic nd;
      #2;
      chk(go_tag(), "go_2d", go_2d, req & (~need_f(0) | pend_m[0]));
      chk(go_tag(), "go_flat", go_fl, req & (~need_f(1) | pend_m[1]));
      chk(ev_tag(), "evt_2d", ev_2d, evt_m[0]);
      chk(ev_tag(), "evt_flat", ev_fl, evt_m[1]);
      @(posedge clk);
      hit_m = ((pol == 2'b01) && s2 && !prv) || ((pol == 2'b10) && !s2 && prv);
      for (int i = 0; i < 2; i++) begin
         nd        = need_f(i);
         g         = req & (~nd | pend_m[i]);
         pend_m[i] = hit_m | (pend_m[i] & ~(g & nd));
         evt_m[i]  = fire_f(i);
      end
      prv = s2;
      s2  = s1;
      s1  = trig;
      @(negedge clk);
   endtask

   task automatic step_hard(string tag, logic exp_go);
      #1;
      chk(tag, "go_directed", go_2d, exp_go);
      step();
   endtask

   task automatic idle_inputs();
      req = 0; bf = 0; rf = 0; lf = 0; be = 0; re = 0; le = 0; ll = 0;
   endtask

   initial begin
      #4000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst = 1; trig = 0; sw = 0; pol = 2'b01; tm = 2'b00; cm = 2'b00;
      idle_inputs();
      req = 1; bf = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk("R1", "go_in_reset", go_2d, 1'b0);
      chk("R1", "evt_in_reset", ev_2d, 1'b0);
      chk("R1", "evt_flat_in_reset", ev_fl, 1'b0);
      rst = 0;
      s1 = 0; s2 = 0; prv = 0;
      for (int i = 0; i < 2; i++) begin pend_m[i] = 0; evt_m[i] = 0; end

      // R3: rising edge latency, gated block-first request held high
      trig = 1;
      step_hard("R3", 1'b0);
      step_hard("R3", 1'b0);
      step_hard("R3", 1'b0);
      step_hard("R3", 1'b1);
      step_hard("R8", 1'b0);

      // R8: two rising edges while idle collapse into one hit
      idle_inputs();
      trig = 0; repeat (4) step();
      trig = 1; repeat (4) step();
      trig = 0; repeat (4) step();
      trig = 1; repeat (4) step();
      req = 1; bf = 1;
      step_hard("R8", 1'b1);
      step_hard("R8", 1'b0);

      // R2: falling polarity sees the falling edge
      idle_inputs();
      pol = 2'b10;
      trig = 0; repeat (4) step();
      req = 1; bf = 1;
      step_hard("R2", 1'b1);
      step_hard("R2", 1'b0);

      // R13: channel-level completion ignores non-last link ends
      idle_inputs();
      cm = 2'b11;
      le = 1; ll = 0; step();
      le = 0; ll = 0; #1; chk("R13", "evt_not_last", ev_2d, 1'b0); step();
      le = 1; ll = 1; step();
      le = 0; ll = 0; #1; chk("R13", "evt_last", ev_2d, 1'b1); step();
      #1; chk("R10", "evt_single_cycle", ev_2d, 1'b0); step();

      // random epochs
      for (int n = 0; n < 4000; n++) begin
         if (n % 40 == 0) begin
            pol = 2'($urandom);
            tm  = 2'($urandom);
            cm  = 2'($urandom);
            sw  = 1'($urandom);
         end
         if ($urandom % 5 == 0) trig = ~trig;
         req = 1'($urandom);
         bf  = ($urandom % 3 == 0);
         rf  = ($urandom % 3 == 0);
         lf  = ($urandom % 3 == 0);
         be  = ($urandom % 4 == 0);
         re  = ($urandom % 4 == 0);
         le  = ($urandom % 4 == 0);
         ll  = 1'($urandom);
         step();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule